// File: doc/BRIEF.md
# Road Hit Retrieval Buffer

This block sits between the per-layer hit streams of a tracking trigger and its road finder. Each layer delivers full-resolution hits. Every accepted hit is written into a per-layer hit store. At the same time, its coarse super-bin value (the upper bits of the hit) is passed on at once to the pattern matcher. Hits are chained into one linked list for each combination of event slot, layer and super-bin. A head table points to the newest entry of each chain.

When the road finder returns a road, the road carries an event tag and one super-bin value for each layer. The block then replays the road to a downstream fitter. It first sends a header word, followed by every stored hit of that event that lies in the road's bins. Layers are visited in ascending order, and within a layer the newest hit comes first. Several events are held at once in tagged slots. Opening a slot clears its chains in a single cycle through a per-slot valid bitmap. A slot cannot be reopened until its final road has been replayed.

Top module: `road_hit_buffer`

## Requirements
- R1: After reset `road_ready` is 1, `out_valid` is 0, `hit_ready` is 0 and every slot is free (`evt_ready` is 1 for any tag).
- R2: In the cycle a hit on layer l is accepted, `sb_valid[l]` is 1, field l of `sb_data` (bits l*SB_W upward) equals the top SB_W bits of that hit, and `sb_evt` equals the tag of the open event.
- R3: Opening an event slot with `evt_start` discards every hit previously stored under that tag.
- R4: One cycle after a road is accepted, a header word appears with `out_hdr`=1, `out_layer`=0 and `out_data` equal to the road's super-bin vector (field l at bits l*SB_W).
- R5: After the header, the matching hits follow one per cycle with no gaps, in ascending layer order, and newest first within a layer. Each hit word carries its layer in `out_layer` and the full hit in `out_data`.
- R6: A layer whose road bin holds no hit of that event contributes no word; a road with no hits at all is a single header word with `out_last`=1.
- R7: `out_last` marks exactly the final word of a road, and `out_valid` is 0 in the cycle after it.
- R8: A slot stays busy from its `evt_start` until the road flagged `road_evt_last` for that tag has been fully replayed; while busy, `evt_ready` is 0 for that tag and the start has no effect.
- R9: Hits of one event are never returned for a road of another event, even when the bins match.
- R10: `hit_ready` is 0 while no event is open and in any cycle where `evt_start` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Open a new write event |
| evt_tag | input | EW | Slot tag of the event being opened |
| evt_ready | output | 1 | Slot named by `evt_tag` is free |
| hit_valid | input | LAYERS | Per-layer hit strobe |
| hit_data | input | LAYERS*HIT_W | Per-layer full-resolution hits |
| hit_ready | output | 1 | Hits can be accepted this cycle |
| sb_valid | output | LAYERS | Per-layer super-bin strobe to road finder |
| sb_data | output | LAYERS*SB_W | Per-layer super-bin values |
| sb_evt | output | EW | Tag of the event being written |
| road_valid | input | 1 | Road offered |
| road_evt | input | EW | Event tag of the road |
| road_sb | input | LAYERS*SB_W | Per-layer super-bins of the road |
| road_evt_last | input | 1 | Final road of this event; frees the slot |
| road_ready | output | 1 | Road can be accepted |
| out_valid | output | 1 | Output word valid |
| out_hdr | output | 1 | Word is a road header |
| out_last | output | 1 | Final word of the road |
| out_layer | output | LW | Layer of a hit word |
| out_data | output | OW | Header bin vector or full hit |

## Verification
The embedded properties check the output framing on every cycle. A header follows each accepted road, a burst has no gaps and no second header, layers never decrease within a road, there is an idle cycle after each last word, and a freshly opened slot reads back as busy. The bench's directed scenarios cover what depends on stored content. These are the newest-first chain order, the skipping of empty bins, the isolation of events that share bins, the clearing of a slot when it is reopened, and the release of a slot only after its final road.

// File: rtl/road_hit_buffer.sv
module road_hit_buffer #(
  parameter int LAYERS = 4,
  parameter int HIT_W  = 16,
  parameter int SB_W   = 4,
  parameter int EVENTS = 16,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_start,
  input  logic [$clog2(EVENTS)-1:0] evt_tag,
  output logic                     evt_ready,
  input  logic [LAYERS-1:0]        hit_valid,
  input  logic [LAYERS*HIT_W-1:0]  hit_data,
  output logic                     hit_ready,
  output logic [LAYERS-1:0]        sb_valid,
  output logic [LAYERS*SB_W-1:0]   sb_data,
  output logic [$clog2(EVENTS)-1:0] sb_evt,
  input  logic                     road_valid,
  input  logic [$clog2(EVENTS)-1:0] road_evt,
  input  logic [LAYERS*SB_W-1:0]   road_sb,
  input  logic                     road_evt_last,
  output logic                     road_ready,
  output logic                     out_valid,
  output logic                     out_hdr,
  output logic                     out_last,
  output logic [$clog2(LAYERS)-1:0] out_layer,
  output logic [((HIT_W > LAYERS*SB_W) ? HIT_W : LAYERS*SB_W)-1:0] out_data
);
  localparam int EW    = $clog2(EVENTS);
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(LAYERS);
  localparam int NSB   = 1 << SB_W;
  localparam int HDR_W = LAYERS * SB_W;
  localparam int OW    = (HIT_W > HDR_W) ? HIT_W : HDR_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_HIT} st_t;

  logic [HIT_W-1:0] hmem [LAYERS][DEPTH];
  logic [AW-1:0]    nmem [LAYERS][DEPTH];
  logic             lmem [LAYERS][DEPTH];
  logic [AW-1:0]    head [LAYERS][EVENTS][NSB];
  logic [NSB-1:0]   vmap [EVENTS][LAYERS];
  logic [AW-1:0]    wptr [LAYERS];
  logic [EVENTS-1:0] busy;
  logic             open_q;
  logic [EW-1:0]    wevt;

  st_t              st;
  logic [EW-1:0]    r_evt;
  logic [HDR_W-1:0] r_sb;
  logic             r_elast;
  logic [LW-1:0]    lay;
  logic [AW-1:0]    ptr;

  logic [SB_W-1:0]  wsb [LAYERS];
  logic [SB_W-1:0]  rsb [LAYERS];
  logic [LAYERS-1:0] ne, hit_fire;
  logic             found, done, rel, start_ok, cur_more;
  logic [LW-1:0]    nlay;

  assign evt_ready = ~busy[evt_tag];
  assign start_ok  = evt_start & evt_ready;
  assign hit_ready = open_q & ~evt_start;
  assign hit_fire  = hit_valid & {LAYERS{hit_ready}};
  assign sb_valid  = hit_fire;
  assign sb_evt    = wevt;

  for (genvar l = 0; l < LAYERS; l++) begin : g_lay
    assign wsb[l] = hit_data[l*HIT_W + HIT_W - 1 -: SB_W];
    assign rsb[l] = r_sb[l*SB_W +: SB_W];
    assign sb_data[l*SB_W +: SB_W] = wsb[l];
    assign ne[l] = vmap[r_evt][l][rsb[l]];
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LAYERS; l++) begin
      if (hit_fire[l]) begin
        hmem[l][wptr[l]] <= hit_data[l*HIT_W +: HIT_W];
        nmem[l][wptr[l]] <= head[l][wevt][wsb[l]];
        lmem[l][wptr[l]] <= vmap[wevt][l][wsb[l]];
        head[l][wevt][wsb[l]] <= wptr[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= '0;
      open_q <= 1'b0;
      wevt   <= '0;
      for (int e = 0; e < EVENTS; e++)
        for (int l = 0; l < LAYERS; l++) vmap[e][l] <= '0;
      for (int l = 0; l < LAYERS; l++) wptr[l] <= '0;
    end else begin
      if (start_ok) begin
        busy[evt_tag] <= 1'b1;
        open_q <= 1'b1;
        wevt   <= evt_tag;
        for (int l = 0; l < LAYERS; l++) vmap[evt_tag][l] <= '0;
      end
      if (rel) busy[r_evt] <= 1'b0;
      for (int l = 0; l < LAYERS; l++) begin
        if (hit_fire[l]) begin
          vmap[wevt][l][wsb[l]] <= 1'b1;
          wptr[l] <= wptr[l] + AW'(1);
        end
      end
    end
  end

  always_comb begin
    found = 1'b0;
    nlay  = '0;
    for (int l = LAYERS - 1; l >= 0; l--) begin
      if (ne[l] && (st == S_HDR || l > int'(lay))) begin
        found = 1'b1;
        nlay  = LW'(l);
      end
    end
  end

  assign cur_more = lmem[lay][ptr];
  assign done = (st == S_HDR && !found) || (st == S_HIT && !cur_more && !found);
  assign rel  = done & r_elast;

  assign road_ready = (st == S_IDLE);
  assign out_valid  = (st != S_IDLE);
  assign out_hdr    = (st == S_HDR);
  assign out_last   = done;
  assign out_layer  = (st == S_HIT) ? lay : '0;
  assign out_data   = (st == S_HDR) ? OW'(r_sb) : OW'(hmem[lay][ptr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_evt   <= '0;
      r_sb    <= '0;
      r_elast <= 1'b0;
      lay     <= '0;
      ptr     <= '0;
    end else begin
      case (st)
        S_IDLE: if (road_valid) begin
          r_evt   <= road_evt;
          r_sb    <= road_sb;
          r_elast <= road_evt_last;
          lay     <= '0;
          st      <= S_HDR;
        end
        S_HDR: if (found) begin
          lay <= nlay;
          ptr <= head[nlay][r_evt][rsb[nlay]];
          st  <= S_HIT;
        end else st <= S_IDLE;
        default: if (cur_more) ptr <= nmem[lay][ptr];
          else if (found) begin
            lay <= nlay;
            ptr <= head[nlay][r_evt][rsb[nlay]];
          end else st <= S_IDLE;
      endcase
    end
  end

  assert_hdr_after_road_R4: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && road_ready |=> out_valid && out_hdr);
  assert_burst_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid && !out_hdr);
  assert_layer_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_layer >= $past(out_layer));
  assert_gap_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |=> !out_valid);
  assert_slot_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start && evt_ready |=> (evt_tag != $past(evt_tag)) || !evt_ready);
endmodule

// File: tb/road_hit_buffer_tb_top.sv
`timescale 1ns/1ps
module road_hit_buffer_tb_top;
  localparam int L = 4, HW = 16, SBW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_start = 1'b0; logic [3:0] evt_tag = '0; logic evt_ready;
  logic [L-1:0] hit_valid = '0; logic [L*HW-1:0] hit_data = '0; logic hit_ready;
  logic [L-1:0] sb_valid; logic [L*SBW-1:0] sb_data; logic [3:0] sb_evt;
  logic road_valid = 1'b0; logic [3:0] road_evt = '0; logic [L*SBW-1:0] road_sb = '0;
  logic road_evt_last = 1'b0; logic road_ready;
  logic out_valid, out_hdr, out_last; logic [1:0] out_layer; logic [15:0] out_data;

  road_hit_buffer dut_i (.clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_tag(evt_tag),
    .evt_ready(evt_ready), .hit_valid(hit_valid), .hit_data(hit_data), .hit_ready(hit_ready),
    .sb_valid(sb_valid), .sb_data(sb_data), .sb_evt(sb_evt), .road_valid(road_valid),
    .road_evt(road_evt), .road_sb(road_sb), .road_evt_last(road_evt_last),
    .road_ready(road_ready), .out_valid(out_valid), .out_hdr(out_hdr), .out_last(out_last),
    .out_layer(out_layer), .out_data(out_data));

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [15:0] mdl [16][L][32];
  int cnt [16][L];
  int cur = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_evt(input int tag, input bit exp_rdy, input string req);
    evt_start = 1'b1; evt_tag = 4'(tag);
    #1;
    chk(evt_ready == exp_rdy, req, "evt_ready", evt_ready, exp_rdy);
    chk(hit_ready == 1'b0, "R10", "hit_ready during start", hit_ready, 0);
    @(negedge clk);
    evt_start = 1'b0;
    if (exp_rdy) begin
      cur = tag;
      for (int l = 0; l < L; l++) cnt[tag][l] = 0;
    end
  endtask

  task automatic put_hit(input int l, input logic [15:0] d);
    hit_valid[l] = 1'b1; hit_data[l*HW +: HW] = d;
    #1;
    chk(sb_valid[l] == 1'b1, "R2", "sb_valid", sb_valid[l], 1);
    chk(sb_data[l*SBW +: SBW] == d[15:12], "R2", "sb_data", sb_data[l*SBW +: SBW], d[15:12]);
    chk(sb_evt == 4'(cur), "R2", "sb_evt", sb_evt, cur);
    @(negedge clk);
    hit_valid[l] = 1'b0;
    mdl[cur][l][cnt[cur][l]] = d;
    cnt[cur][l]++;
  endtask

  task automatic run_road(input int evt, input logic [15:0] sbv, input bit last_of_evt,
                          input string req);
    int n = 0;
    int el [64];
    logic [15:0] ed [64];
    for (int l = 0; l < L; l++)
      for (int i = cnt[evt][l] - 1; i >= 0; i--)
        if (mdl[evt][l][i][15:12] == sbv[l*SBW +: SBW]) begin
          el[n] = l; ed[n] = mdl[evt][l][i]; n++;
        end
    road_valid = 1'b1; road_evt = 4'(evt); road_sb = sbv; road_evt_last = last_of_evt;
    #1;
    chk(road_ready == 1'b1, "R4", "road_ready", road_ready, 1);
    @(negedge clk);
    road_valid = 1'b0; road_evt_last = 1'b0;
    chk(out_valid && out_hdr, "R4", "header present", {out_valid, out_hdr}, 3);
    chk(out_data == sbv, "R4", "header data", out_data, sbv);
    chk(out_layer == 0, "R4", "header layer", out_layer, 0);
    chk(out_last == (n == 0), "R6", "header last", out_last, n == 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(out_valid && !out_hdr, req, "hit word valid", {out_valid, out_hdr}, 2);
      chk(out_layer == 2'(el[i]), req, "hit layer", out_layer, el[i]);
      chk(out_data == ed[i], req, "hit data", out_data, ed[i]);
      chk(out_last == (i == n - 1), "R7", "last flag", out_last, i == n - 1);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "idle after last", out_valid, 0);
  endtask

  task automatic t_reset();
    chk(road_ready == 1'b1, "R1", "road_ready", road_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(hit_ready == 1'b0, "R10", "hit_ready closed", hit_ready, 0);
    evt_tag = 4'd9; #1;
    chk(evt_ready == 1'b1, "R1", "slot free", evt_ready, 1);
  endtask

  task automatic t_basic();
    start_evt(0, 1, "R3");
    put_hit(0, 16'h3101); put_hit(0, 16'h3102); put_hit(0, 16'h5100);
    put_hit(0, 16'h3103); put_hit(1, 16'h3201); put_hit(2, 16'h4444);
    put_hit(3, 16'h7301); put_hit(3, 16'h7302);
    run_road(0, 16'h7333, 1'b0, "R5");
  endtask

  task automatic t_empty();
    run_road(0, 16'h9999, 1'b0, "R6");
    run_road(0, 16'h7999, 1'b0, "R6");
  endtask

  task automatic t_isolation();
    start_evt(1, 1, "R3");
    put_hit(0, 16'h3aaa);
    run_road(1, 16'h3333, 1'b0, "R9");
    run_road(0, 16'h3333, 1'b0, "R9");
  endtask

  task automatic t_stall();
    start_evt(0, 0, "R8");
    put_hit(1, 16'h3bcd);
    run_road(0, 16'h3333, 1'b1, "R8");
    start_evt(0, 1, "R8");
    put_hit(0, 16'h3bbb);
    run_road(0, 16'h3333, 1'b0, "R3");
    run_road(1, 16'h3333, 1'b0, "R9");
  endtask

  initial begin
    #500000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_basic();
    t_empty();
    t_isolation();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule